// File: doc/BRIEF.md
# Multiple-Register Transfer Sequencer

This block carries out a block move between a sixteen-entry register file and memory, as the micro-sequencer of a processor's multi-register move instruction would. On a start pulse it takes the instruction word, which sets direction, operand size and addressing mode, along with a 16-bit register select mask, an effective address that has already been computed, and the current value of the addressing register. It then walks the mask one register at a time. Each transfer goes through a request/acknowledge memory port. Register values are read through a combinational read port and written through a single write port.

Stores in pre-decrement mode walk the register file from the top index down, at falling addresses. All other transfers walk upward at rising addresses. Loads place every value read into an internal staging buffer. The register file is written only after the last memory read has been acknowledged, so a fault during the reads leaves every register untouched. For the two auto-addressing modes, the final address is written back into the base register when the transfer ends.

Top module: `mreg_xfer_seq`

## Requirements
- R1: Instruction bit 10 set means memory to registers (load), clear means registers to memory (store). Instruction bit 6 set means 32-bit transfers with a 4-byte address step; clear means 16-bit transfers with a 2-byte step. For 16-bit stores only the low 16 bits of `mem_wdata` carry data.
- R2: In upward walks, mask bit i selects register index i. Indices 0..7 are data registers and 8..15 are address registers.
- R3: Instruction bits 5:3 equal to 4 on a store select pre-decrement mode. In this mode mask bit j selects register 15-j, and registers go out from the highest index to the lowest. The first store uses the supplied address, and each later store uses an address one step lower.
- R4: At the end of a pre-decrement store, the base register (index 8 + instruction bits 2:0) is written with the supplied address minus (n-1) steps, where n is the number of selected registers.
- R5: In pre-decrement mode, when the register being stored is the base register, the stored value is its initial value minus one step if `ext_feature` is 1, and its initial value if `ext_feature` is 0.
- R6: Stores in modes other than 4 go from index 0 upward, at addresses rising by one step from the supplied address. No register is written.
- R7: Loads read from index 0 upward, at addresses rising by one step. Each selected register receives the value read from its own address. No register write occurs before the last read is acknowledged.
- R8: A load with instruction bits 5:3 equal to 3 (post-increment) writes the supplied address plus n steps to the base register after the data writes. Loads in other modes write only the selected registers.
- R9: A 16-bit load writes the low half of the read data into the register, sign-extended to 32 bits.
- R10: With an empty mask, `done` is high in the first cycle after the start cycle and no memory request is made. In the auto-addressing modes the base register is written with the unchanged supplied address in that same cycle.
- R11: A `mem_fault` on a pending request ends the transfer. The block returns to idle, pulses `fault_err` in the following cycle, never raises `done`, and writes no register.
- R12: After reset `busy`, `done`, `mem_req` and `rf_we` are low. While a request waits for acknowledge, its address and direction stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts a transfer; sampled only while idle |
| op_word | input | 16 | Instruction word: bit 10 direction, bit 6 size, bits 5:3 mode, bits 2:0 base register |
| reg_mask | input | 16 | Register select mask |
| ea_addr | input | AW (32) | Precomputed effective address of the first transfer |
| base_val | input | DW (32) | Current value of the base address register |
| ext_feature | input | 1 | Selects the adjusted value when the base register is itself stored in pre-decrement mode |
| busy | output | 1 | High whenever the block is not idle |
| done | output | 1 | One-cycle pulse on normal completion |
| fault_err | output | 1 | One-cycle pulse after a transfer aborted by a fault |
| mem_req | output | 1 | Memory request pending |
| mem_we | output | 1 | High for a memory write |
| mem_long | output | 1 | High for a 32-bit access, low for 16-bit |
| mem_addr | output | AW (32) | Memory byte address |
| mem_wdata | output | DW (32) | Memory write data |
| mem_ack | input | 1 | Completes the pending request at this clock edge |
| mem_fault | input | 1 | Aborts the pending request at this clock edge |
| mem_rdata | input | DW (32) | Read data, valid with `mem_ack` |
| rf_raddr | output | 4 | Register file read index |
| rf_rdata | input | DW (32) | Register file read data (combinational) |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 4 | Register file write index |
| rf_wdata | output | DW (32) | Register file write data |

## Verification
An acknowledge or fault seen at a rising edge takes effect at that edge. The next request, or the first register write, appears in the cycle that follows. A store raises `done` one cycle after its last acknowledge. A load spends one cycle per selected register on data writes and then raises `done`. An empty mask raises `done` in the first cycle after start, and `fault_err` rises one cycle after the faulting edge. The bench drives and samples on falling edges. It logs every accepted memory transaction and every register write against the cycle in which it occurred, and after `done` or `fault_err` it compares those logs against sequences computed from the requirements. Write-before-last-read ordering is checked from the logged cycle numbers, and the empty-mask latency is counted in falling edges.

// File: rtl/mrx_pkg.sv
package mrx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_MOVE,
      ST_COMMIT,
      ST_FINISH
   } mrx_state_e;

   localparam int DIR_BIT  = 10;
   localparam int SIZE_BIT = 6;
   localparam int MODE_LSB = 3;

   localparam logic [2:0] AM_POSTINC = 3'd3;
   localparam logic [2:0] AM_PREDEC  = 3'd4;
endpackage

// File: rtl/mrx_pick.sv
// Priority picker over a pending-register bit vector: lowest set index when
// walking upward, highest set index when walking downward.
module mrx_pick #(
   parameter int N  = 16,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0]  bits,
   input  logic          from_top,
   output logic          any,
   output logic [IW-1:0] idx,
   output logic          single
);
   if (N < 2) begin : g_bad_n
      $error("mrx_pick: N must be at least 2");
   end

   always_comb begin
      idx = '0;
      if (from_top) begin
         for (int i = 0; i < N; i++) begin
            if (bits[i]) idx = IW'(i);
         end
      end else begin
         for (int i = N - 1; i >= 0; i--) begin
            if (bits[i]) idx = IW'(i);
         end
      end
   end

   assign any    = |bits;
   assign single = any && ((bits & (bits - N'(1))) == '0);
endmodule

// File: rtl/mrx_stage.sv
// Holding buffer for loaded values; registers update only after all reads.
module mrx_stage #(
   parameter int N  = 16,
   parameter int DW = 32,
   parameter int IW = $clog2(N)
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [DW-1:0] wr_data,
   input  logic [IW-1:0] rd_idx,
   output logic [DW-1:0] rd_data
);
   logic [DW-1:0] slots [N];

   always_ff @(posedge clk) begin
      if (wr_en) slots[wr_idx] <= wr_data;
   end

   assign rd_data = slots[rd_idx];
endmodule

// File: rtl/mreg_xfer_seq.sv
module mreg_xfer_seq
   import mrx_pkg::*;
#(
   parameter int NREGS = 16,
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int IW    = $clog2(NREGS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [15:0]   op_word,
   input  logic [NREGS-1:0] reg_mask,
   input  logic [AW-1:0] ea_addr,
   input  logic [DW-1:0] base_val,
   input  logic          ext_feature,
   output logic          busy,
   output logic          done,
   output logic          fault_err,
   output logic          mem_req,
   output logic          mem_we,
   output logic          mem_long,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic          mem_ack,
   input  logic          mem_fault,
   input  logic [DW-1:0] mem_rdata,
   output logic [IW-1:0] rf_raddr,
   input  logic [DW-1:0] rf_rdata,
   output logic          rf_we,
   output logic [IW-1:0] rf_waddr,
   output logic [DW-1:0] rf_wdata
);
   // elaboration-time parameter checks
   if (NREGS != 16) begin : g_bad_nregs
      $error("mreg_xfer_seq: register select encoding needs NREGS == 16");
   end
   if (IW != $clog2(NREGS)) begin : g_bad_iw
      $error("mreg_xfer_seq: IW must equal clog2(NREGS)");
   end
   if (DW <= 16) begin : g_bad_dw
      $error("mreg_xfer_seq: DW must exceed the 16-bit transfer size");
   end
   if (AW > DW || AW < 3) begin : g_bad_aw
      $error("mreg_xfer_seq: AW must fit in a register and hold a step");
   end

   localparam int HALF = NREGS / 2;

   mrx_state_e        st;
   logic [NREGS-1:0]  rem_q, cmt_q, mask_rev;
   logic [AW-1:0]     addr_q, step_a;
   logic [DW-1:0]     base_q, step_d, own_val, load_val, stage_rd;
   logic              load_q, long_q, pre_q, wb_q, ext_q;
   logic [IW-2:0]     breg_q;
   logic [IW-1:0]     base_idx;

   logic              walk_any, walk_last, cmt_any, cmt_last;
   logic [IW-1:0]     walk_idx, cmt_idx;
   logic              own_hit, stage_we;

   logic              s_load, s_pre, s_wb;
   logic [2:0]        s_mode;
   logic              unused_opbits;

   assign unused_opbits = ^{op_word[15:11], op_word[9:7]};

   // start-time decode of the instruction word
   assign s_load = op_word[DIR_BIT];
   assign s_mode = op_word[MODE_LSB +: 3];
   assign s_pre  = !s_load && (s_mode == AM_PREDEC);
   assign s_wb   = s_pre || (s_load && (s_mode == AM_POSTINC));

   // pre-decrement mask: bit j selects register NREGS-1-j
   for (genvar g = 0; g < NREGS; g++) begin : g_rev
      assign mask_rev[g] = reg_mask[NREGS-1-g];
   end

   mrx_pick #(.N(NREGS), .IW(IW)) u_walk (
      .bits(rem_q), .from_top(pre_q),
      .any(walk_any), .idx(walk_idx), .single(walk_last)
   );

   mrx_pick #(.N(NREGS), .IW(IW)) u_commit (
      .bits(cmt_q), .from_top(1'b0),
      .any(cmt_any), .idx(cmt_idx), .single(cmt_last)
   );

   assign step_a   = long_q ? AW'(4) : AW'(2);
   assign step_d   = long_q ? DW'(4) : DW'(2);
   assign base_idx = {1'b1, breg_q};
   assign own_hit  = pre_q && (walk_idx == base_idx);
   assign own_val  = ext_q ? (base_q - step_d) : base_q;
   assign load_val = long_q ? mem_rdata
                            : {{(DW-16){mem_rdata[15]}}, mem_rdata[15:0]};
   assign stage_we = (st == ST_MOVE) && mem_ack && !mem_fault && load_q;

   mrx_stage #(.N(NREGS), .DW(DW), .IW(IW)) u_stage (
      .clk(clk), .wr_en(stage_we), .wr_idx(walk_idx), .wr_data(load_val),
      .rd_idx(cmt_idx), .rd_data(stage_rd)
   );

   // port-side decode
   assign busy      = (st != ST_IDLE);
   assign done      = (st == ST_FINISH);
   assign mem_req   = (st == ST_MOVE);
   assign mem_we    = mem_req && !load_q;
   assign mem_long  = long_q;
   assign mem_addr  = addr_q;
   assign mem_wdata = own_hit ? own_val : rf_rdata;
   assign rf_raddr  = walk_idx;
   assign rf_we     = (st == ST_COMMIT) || ((st == ST_FINISH) && wb_q);
   assign rf_waddr  = (st == ST_COMMIT) ? cmt_idx : base_idx;
   assign rf_wdata  = (st == ST_COMMIT) ? stage_rd : DW'(addr_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         rem_q     <= '0;
         cmt_q     <= '0;
         addr_q    <= '0;
         base_q    <= '0;
         load_q    <= 1'b0;
         long_q    <= 1'b0;
         pre_q     <= 1'b0;
         wb_q      <= 1'b0;
         ext_q     <= 1'b0;
         breg_q    <= '0;
         fault_err <= 1'b0;
      end else begin
         fault_err <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (start) begin
                  load_q <= s_load;
                  long_q <= op_word[SIZE_BIT];
                  pre_q  <= s_pre;
                  wb_q   <= s_wb;
                  ext_q  <= ext_feature;
                  breg_q <= op_word[IW-2:0];
                  addr_q <= ea_addr;
                  base_q <= base_val;
                  rem_q  <= s_pre ? mask_rev : reg_mask;
                  cmt_q  <= s_load ? reg_mask : '0;
                  st     <= (reg_mask == '0) ? ST_FINISH : ST_MOVE;
               end
            end
            ST_MOVE: begin
               if (mem_fault) begin
                  rem_q     <= '0;
                  cmt_q     <= '0;
                  fault_err <= 1'b1;
                  st        <= ST_IDLE;
               end else if (mem_ack) begin
                  rem_q[walk_idx] <= 1'b0;
                  if (pre_q) begin
                     if (!walk_last) addr_q <= addr_q - step_a;
                  end else begin
                     addr_q <= addr_q + step_a;
                  end
                  if (walk_last) st <= load_q ? ST_COMMIT : ST_FINISH;
               end
            end
            ST_COMMIT: begin
               cmt_q[cmt_idx] <= 1'b0;
               if (cmt_last) st <= ST_FINISH;
            end
            ST_FINISH: st <= ST_IDLE;
            default:   st <= ST_IDLE;
         endcase
      end
   end

   // the walker always has a register to move while a request is pending
   assert_walk_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> walk_any);

   assert_commit_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_COMMIT) |-> cmt_any);

   // no register update while memory is still being accessed
   assert_no_early_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !rf_we);

   // request stays put until acknowledged or faulted
   assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack && !mem_fault) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // descending step between pre-decrement stores
   assert_predec_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && pre_q && mem_ack && !mem_fault && !walk_last)
      |=> (mem_addr == $past(mem_addr) - $past(step_a)));

   // a fault aborts with an error pulse and touches no register
   assert_fault_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_fault) |=> (!busy && !rf_we && fault_err));

   // empty mask completes right after start without memory traffic
   assert_empty_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && (reg_mask == '0)) |=> (done && !mem_req));

   // completion write targets the base register only
   assert_wb_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rf_we) |-> (rf_waddr >= IW'(HALF)));
endmodule

// File: tb/tb_mreg_xfer_seq.sv
module tb_mreg_xfer_seq;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic        start = 1'b0;
   logic [15:0] op_word = '0, reg_mask = '0;
   logic [31:0] ea_addr = '0, base_val = '0;
   logic        ext_feature = 1'b0;
   logic        busy, done, fault_err, mem_req, mem_we, mem_long;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ack = 1'b0, mem_fault = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic [3:0]  rf_raddr, rf_waddr;
   logic [31:0] rf_rdata, rf_wdata;
   logic        rf_we;
   logic [31:0] regs [16];

   assign rf_rdata = regs[rf_raddr];

   mreg_xfer_seq dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op_word(op_word),
      .reg_mask(reg_mask), .ea_addr(ea_addr), .base_val(base_val),
      .ext_feature(ext_feature), .busy(busy), .done(done), .fault_err(fault_err),
      .mem_req(mem_req), .mem_we(mem_we), .mem_long(mem_long), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_fault(mem_fault),
      .mem_rdata(mem_rdata), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
      .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
   );

   int total = 0, bad = 0, cyc = 0, wait_cnt = 0, fault_at = -1;
   int m_cnt = 0, w_cnt = 0, last_ack = -1, first_w = -1;
   int last_n = 0;
   logic last_fault = 1'b0;
   logic [31:0] m_addr [64];
   logic [31:0] m_data [64];
   logic        m_we   [64];
   logic [3:0]  w_idx  [64];
   logic [31:0] w_data [64];
   logic        prev_hold = 1'b0;
   logic [31:0] prev_addr = '0;

   function automatic logic [31:0] pat(input logic [31:0] a);
      logic [15:0] lo;
      lo = (a[15:0] * 16'h9E37) ^ 16'h8421;
      return {a[15:0] ^ 16'h3C5A, lo};
   endfunction

   task automatic chk(input logic ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   // memory responder, transaction and register-write logger
   always @(negedge clk) begin
      cyc++;
      mem_ack   = 1'b0;
      mem_fault = 1'b0;
      if (rst_n && mem_req) begin
         if (prev_hold)
            chk(mem_addr == prev_addr, "R12", "address held while waiting", mem_addr, prev_addr);
         if (wait_cnt > 0) begin
            wait_cnt--;
            prev_hold = 1'b1;
            prev_addr = mem_addr;
         end else begin
            if (fault_at == m_cnt) begin
               mem_fault = 1'b1;
               fault_at  = -1;
            end else begin
               mem_ack   = 1'b1;
               mem_rdata = pat(mem_addr);
               if (m_cnt < 64) begin
                  m_addr[m_cnt] = mem_addr;
                  m_data[m_cnt] = mem_wdata;
                  m_we[m_cnt]   = mem_we;
               end
               m_cnt++;
               last_ack = cyc;
            end
            wait_cnt  = int'($urandom % 3);
            prev_hold = 1'b0;
         end
      end else begin
         prev_hold = 1'b0;
      end
      if (rst_n && rf_we) begin
         if (w_cnt < 64) begin
            w_idx[w_cnt]  = rf_waddr;
            w_data[w_cnt] = rf_wdata;
         end
         if (first_w < 0) first_w = cyc;
         regs[rf_waddr] = rf_wdata;
         w_cnt++;
      end
      if (cyc == 150000) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d expected=below 150000 cycles", cyc);
         finish_run();
      end
   end

   task automatic run_op(input logic ld, input logic lng, input logic [2:0] md,
                         input logic [2:0] br, input logic [15:0] msk,
                         input logic [31:0] ea, input logic ex, input int fk);
      logic [31:0] pre [16];
      logic [3:0]  e_idx [20];
      logic [31:0] e_val [20];
      int          e_cnt, k, left, n;
      logic [31:0] a, step, val, dmask, rd;
      logic [3:0]  bidx, idx;
      logic        pre_st;
      string       atag;

      for (int i = 0; i < 16; i++) pre[i] = regs[i];
      bidx = {1'b1, br};
      @(negedge clk);
      op_word     = {5'b01001, ld, 3'b001, lng, md, br};
      reg_mask    = msk;
      ea_addr     = ea;
      base_val    = regs[bidx];
      ext_feature = ex;
      fault_at    = fk;
      m_cnt = 0; w_cnt = 0; last_ack = -1; first_w = -1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n = 1;
      while (!(done || fault_err) && n < 200) begin
         @(negedge clk);
         n++;
      end
      last_n     = n;
      last_fault = fault_err;
      #1;
      chk(n < 200, "R12", "transfer completes", 32'(n), 32'd200);

      if (fk >= 0) begin
         chk(last_fault, "R11", "fault_err pulse", 32'(last_fault), 32'd1);
         chk(w_cnt == 0, "R11", "no register written on fault", 32'(w_cnt), 32'd0);
         chk(m_cnt == fk, "R11", "accepted reads before fault", 32'(m_cnt), 32'(fk));
         chk(!busy, "R11", "idle after fault", 32'(busy), 32'd0);
         return;
      end

      step   = lng ? 32'd4 : 32'd2;
      dmask  = lng ? 32'hFFFF_FFFF : 32'h0000_FFFF;
      pre_st = !ld && (md == 3'd4);
      atag   = pre_st ? "R3" : (ld ? "R7" : "R6");
      left   = $countones(msk);
      chk(m_cnt == left, atag, "transfer count", 32'(m_cnt), 32'(left));
      a = ea; k = 0; e_cnt = 0;
      for (int j = 0; j < 16; j++) begin
         if (msk[j]) begin
            idx = pre_st ? 4'(15 - j) : 4'(j);
            if (k < m_cnt && k < 64) begin
               chk(m_addr[k] == a, atag, "transfer address", m_addr[k], a);
               chk(m_we[k] == !ld, "R1", "transfer direction", 32'(m_we[k]), 32'(!ld));
               if (!ld) begin
                  if (pre_st && idx == bidx)
                     val = ex ? pre[idx] - step : pre[idx];
                  else
                     val = pre[idx];
                  chk((m_data[k] & dmask) == (val & dmask),
                      (pre_st && idx == bidx) ? "R5" : atag, "stored value",
                      m_data[k] & dmask, val & dmask);
               end
            end
            if (ld) begin
               rd = pat(a);
               e_idx[e_cnt] = idx;
               e_val[e_cnt] = lng ? rd : {{16{rd[15]}}, rd[15:0]};
               e_cnt++;
            end
            k++;
            left--;
            if (pre_st) begin
               if (left > 0) a = a - step;
            end else begin
               a = a + step;
            end
         end
      end
      if (pre_st || (ld && md == 3'd3)) begin
         e_idx[e_cnt] = bidx;
         e_val[e_cnt] = a;
         e_cnt++;
      end
      chk(w_cnt == e_cnt, ld ? "R8" : "R6", "register write count", 32'(w_cnt), 32'(e_cnt));
      for (int i = 0; i < e_cnt && i < w_cnt; i++) begin
         chk(w_idx[i] == e_idx[i], ld ? "R7" : "R4", "write index", 32'(w_idx[i]), 32'(e_idx[i]));
         chk(w_data[i] == e_val[i], lng ? "R7" : "R9", "write value", w_data[i], e_val[i]);
      end
      if (ld && msk != 16'h0)
         chk(first_w > last_ack, "R7", "writes after last read", 32'(first_w), 32'(last_ack + 1));
   endtask

   initial begin
      logic [31:0] ea;
      logic [31:0] p;
      int unsigned seed_init;
      seed_init = $urandom(32'd4711);
      for (int i = 0; i < 16; i++) regs[i] = $urandom;
      repeat (3) @(negedge clk);
      chk(!busy && !done && !mem_req && !rf_we, "R12", "reset state",
          {28'h0, busy, done, mem_req, rf_we}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // all sixteen registers, base A4 in the list, adjusted value
      for (int i = 0; i < 8; i++) regs[i] = 32'(i + 8);
      for (int i = 0; i < 4; i++) regs[8 + i] = 32'(i + 1);
      regs[12] = 32'h8000_20EC; regs[13] = 32'd5; regs[14] = 32'd6; regs[15] = 32'd7;
      run_op(1'b0, 1'b1, 3'd4, 3'd4, 16'hFFFF, 32'h8000_20E8, 1'b1, -1);
      chk(m_data[3] == 32'h8000_20E8, "R5", "own register stored minus step", m_data[3], 32'h8000_20E8);
      chk(w_data[0] == 32'h8000_20AC, "R4", "final pre-decrement address", w_data[0], 32'h8000_20AC);
      regs[12] = 32'h8000_20EC;
      run_op(1'b0, 1'b1, 3'd4, 3'd4, 16'hFFFF, 32'h8000_20E8, 1'b0, -1);
      chk(m_data[3] == 32'h8000_20EC, "R5", "own register stored unchanged", m_data[3], 32'h8000_20EC);

      // index mapping on an upward store
      run_op(1'b0, 1'b1, 3'd5, 3'd1, 16'h0101, 32'h0000_4000, 1'b0, -1);
      chk(m_data[0] == regs[0], "R2", "bit 0 is D0", m_data[0], regs[0]);
      chk(m_data[1] == regs[8], "R2", "bit 8 is A0", m_data[1], regs[8]);

      // empty masks
      run_op(1'b0, 1'b1, 3'd4, 3'd2, 16'h0000, 32'h0000_2222, 1'b1, -1);
      chk(last_n == 1, "R10", "empty store done latency", 32'(last_n), 32'd1);
      chk(w_cnt == 1 && w_data[0] == 32'h0000_2222, "R10", "empty pre-decrement write-back", w_data[0], 32'h0000_2222);
      run_op(1'b1, 1'b0, 3'd3, 3'd6, 16'h0000, 32'h0000_3332, 1'b0, -1);
      chk(last_n == 1 && m_cnt == 0, "R10", "empty post-increment load", 32'(last_n), 32'd1);
      run_op(1'b1, 1'b1, 3'd2, 3'd0, 16'h0000, 32'h0000_5000, 1'b0, -1);
      chk(w_cnt == 0, "R10", "empty plain load writes nothing", 32'(w_cnt), 32'd0);

      // sign extension of a negative halfword
      ea = 32'h0000_6000;
      p = pat(ea);
      while (!p[15]) begin
         ea = ea + 32'd2;
         p = pat(ea);
      end
      run_op(1'b1, 1'b0, 3'd2, 3'd3, 16'h0004, ea, 1'b0, -1);
      chk(w_data[0][31:16] == 16'hFFFF, "R9", "upper half of negative word", {16'h0, w_data[0][31:16]}, 32'h0000_FFFF);

      // word post-increment load
      run_op(1'b1, 1'b0, 3'd3, 3'd5, 16'h8421, 32'h0000_7000, 1'b0, -1);

      // faults during loads
      run_op(1'b1, 1'b1, 3'd3, 3'd2, 16'hFFFF, 32'h0000_8000, 1'b0, 5);
      run_op(1'b1, 1'b0, 3'd2, 3'd1, 16'h00F0, 32'h0000_9000, 1'b0, 0);

      // constrained random mix
      for (int t = 0; t < 250; t++) begin
         logic ld, lng, ex;
         logic [2:0] md, br;
         logic [15:0] msk;
         int fk, sel;
         for (int i = 0; i < 16; i++) regs[i] = $urandom;
         ld  = 1'($urandom % 2);
         lng = 1'($urandom % 2);
         ex  = 1'($urandom % 2);
         br  = 3'($urandom % 8);
         sel = int'($urandom % 5);
         if (ld) md = (sel == 0) ? 3'd2 : (sel == 1) ? 3'd3 : (sel == 2) ? 3'd5 : (sel == 3) ? 3'd6 : 3'd7;
         else    md = (sel == 0) ? 3'd2 : (sel == 1) ? 3'd4 : (sel == 2) ? 3'd5 : (sel == 3) ? 3'd6 : 3'd4;
         msk = 16'($urandom);
         if ($urandom % 6 == 0) msk = msk & 16'($urandom) & 16'($urandom);
         fk = -1;
         if (ld && msk != 16'h0 && ($urandom % 8 == 0))
            fk = int'($urandom % 32'($countones(msk)));
         run_op(ld, lng, md, br, msk, 32'h8000_1000 + 32'($urandom % 256) * 32'd4, ex, fk);
      end

      finish_run();
   end
endmodule